// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block keeps the coherence state of one cache line in a writeback cache that shares a snooping bus with other caches. It follows the four-state invalidation scheme: Modified, Exclusive, Shared and Invalid. The block serves a processor port and a bus master port. It also answers snoops from other masters. The line's data is held inside the block.

On a read miss the controller issues a bus read. When the grant arrives it samples the wired-OR shared wire. If no other cache claims the line, the fill lands in Exclusive, so a later store can go to Modified without any bus traffic. If the wire is asserted, the fill lands in Shared. A store to a Shared or Invalid line needs a read-for-ownership on the bus.

When the controller snoops a bus read, it drives the shared wire if it holds the line in any valid state. It hands data cache-to-cache whenever it can. A dirty or exclusive holder always supplies the data. A clean shared holder supplies it only when an outside arbiter names it as the supplier. A flush from Modified also writes memory, so the line is clean once it becomes Shared.

Top module: `mesi_line_ctrl`

## Requirements
- R1: A read that misses raises `bus_req` with `bus_cmd`=0 (read) in the cycle after acceptance. On the grant cycle `bus_shared_in` is sampled. One cycle later `pr_done` pulses and `coh_state` reads 2 (Exclusive) if the wire was low or 1 (Shared) if it was high. `pr_rdata` carries the fill data.
- R2: A write accepted while `coh_state` is 2 (Exclusive) gives `coh_state`=3 (Modified) and `pr_done` one cycle later, with `bus_req` left low.
- R3: A write accepted while `coh_state` is 1 or 0 raises `bus_req` with `bus_cmd`=1 (read-exclusive). One cycle after the grant the line is 3 (Modified) and holds the write data.
- R4: Reads hitting states 1, 2 or 3 and writes hitting state 3 complete with `pr_done` one cycle after acceptance. They raise no `bus_req`. The state is unchanged and `pr_rdata` returns the line data (or the write data for a write).
- R5: A snooped read (`snp_cmd`=0) on state 3 or 2 drives `flush_valid` with the line data one cycle later and moves the line to 1. `mem_wr` is raised alongside the flush only when the line was 3.
- R6: A snooped read-exclusive (`snp_cmd`=1) on state 3 or 2 flushes and moves the line to 0. On state 1 it flushes only if `snp_supplier` is high, and it moves the line to 0 either way.
- R7: A snooped read on state 1 flushes only if `snp_supplier` is high. The line stays in state 1.
- R8: `snp_shared_out` pulses one cycle after a snooped read to a line in state 1, 2 or 3. It stays low after a read-exclusive snoop.
- R9: A snoop of either kind to a line in state 0 produces no flush, no shared indication and no memory write, and the line stays in state 0.
- R10: A snoop wins over the processor: `pr_ready` is low while `snp_valid` is high. A snoop taken while a bus request is pending updates the state. The later grant then fills the line as in R1 or R3.
- R11: After reset `coh_state` is 0 and `pr_done`, `bus_req`, `flush_valid`, `snp_shared_out` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pr_valid | input | 1 | Processor request present |
| pr_write | input | 1 | Request is a store |
| pr_wdata | input | DATA_W | Store data |
| pr_ready | output | 1 | Request accepted this cycle if valid |
| pr_done | output | 1 | Request completed pulse |
| pr_rdata | output | DATA_W | Line data returned on completion |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 1 | 0 read, 1 read-exclusive |
| bus_gnt | input | 1 | Bus granted to this controller this cycle |
| bus_shared_in | input | 1 | Wired-OR shared wire, sampled with the grant |
| bus_fill_data | input | DATA_W | Fill data valid with the grant |
| snp_valid | input | 1 | Another master's transaction is visible |
| snp_cmd | input | 1 | Snooped command, 0 read, 1 read-exclusive |
| snp_supplier | input | 1 | This cache is the chosen clean supplier |
| snp_shared_out | output | 1 | Drive onto the shared wire |
| flush_valid | output | 1 | Line data driven onto the bus |
| flush_data | output | DATA_W | Flushed line data |
| mem_wr | output | 1 | Memory takes the flushed data |
| coh_state | output | 2 | Current state, 0 I, 1 S, 2 E, 3 M |

## Verification
Hits complete one cycle after acceptance. A miss raises its bus request one cycle after acceptance and completes one cycle after its grant. Every snoop response and snoop state change appears exactly one cycle after the snoop cycle. The bench drives inputs on falling edges and reads the registered results at the next falling edge after the edge that loads them. It checks the combinational `pr_ready` a short delay after driving `snp_valid`. A reference model kept as bench functions supplies the expected state, flush, shared and memory-write values, including for snoops placed inside a pending miss.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
   typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} coh_t;
   typedef enum logic {CMD_RD = 1'b0, CMD_RDX = 1'b1} bcmd_t;

   typedef struct packed {
      logic  hit;
      coh_t  nxt;
      bcmd_t cmd;
   } pr_dec_t;

   typedef struct packed {
      coh_t nxt;
      logic flush;
      logic shared;
      logic mem_upd;
   } snp_dec_t;
endpackage

// File: rtl/mesi_proc_dec.sv
module mesi_proc_dec
   import mesi_pkg::*;
(
   input  coh_t    cur,
   input  logic    write,
   output pr_dec_t dec
);
   always_comb begin
      dec.hit = 1'b0;
      dec.nxt = cur;
      dec.cmd = CMD_RD;
      if (write) begin
         dec.cmd = CMD_RDX;
         if (cur == ST_M || cur == ST_E) begin
            dec.hit = 1'b1;
            dec.nxt = ST_M;
         end
      end else begin
         dec.hit = (cur != ST_I);
      end
   end
endmodule

// File: rtl/mesi_snoop_dec.sv
module mesi_snoop_dec
   import mesi_pkg::*;
#(
   parameter bit CLEAN_SUPPLY = 1'b1
)(
   input  coh_t     cur,
   input  bcmd_t    cmd,
   input  logic     supplier,
   output snp_dec_t dec
);
   logic owner_like;
   logic clean_flush;

   assign owner_like = (cur == ST_M) || (cur == ST_E);

   generate
      if (CLEAN_SUPPLY) begin : g_clean_supply
         assign clean_flush = (cur == ST_S) && supplier;
      end else begin : g_mem_supply
         assign clean_flush = 1'b0;
      end
   endgenerate

   always_comb begin
      dec.flush   = owner_like || clean_flush;
      dec.mem_upd = (cur == ST_M);
      dec.shared  = (cmd == CMD_RD) && (cur != ST_I);
      if (cur == ST_I)
         dec.nxt = ST_I;
      else if (cmd == CMD_RDX)
         dec.nxt = ST_I;
      else
         dec.nxt = ST_S;
   end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit CLEAN_SUPPLY = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pr_valid,
   input  logic              pr_write,
   input  logic [DATA_W-1:0] pr_wdata,
   output logic              pr_ready,
   output logic              pr_done,
   output logic [DATA_W-1:0] pr_rdata,
   output logic              bus_req,
   output logic              bus_cmd,
   input  logic              bus_gnt,
   input  logic              bus_shared_in,
   input  logic [DATA_W-1:0] bus_fill_data,
   input  logic              snp_valid,
   input  logic              snp_cmd,
   input  logic              snp_supplier,
   output logic              snp_shared_out,
   output logic              flush_valid,
   output logic [DATA_W-1:0] flush_data,
   output logic              mem_wr,
   output logic [1:0]        coh_state
);
   localparam int LINE_W = DATA_W;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("mesi_line_ctrl: DATA_W must be at least 1");
      end
   endgenerate

   coh_t              st_q;
   logic [LINE_W-1:0] line_q;
   logic              wait_q;
   logic              pend_wr_q;
   logic [LINE_W-1:0] pend_data_q;
   bcmd_t             cmd_q;
   pr_dec_t           pd;
   snp_dec_t          sd;
   logic              accept;
   logic              grant;
   logic              snp_take;

   mesi_proc_dec u_proc_dec (
      .cur   (st_q),
      .write (pr_write),
      .dec   (pd)
   );

   mesi_snoop_dec #(.CLEAN_SUPPLY(CLEAN_SUPPLY)) u_snoop_dec (
      .cur      (st_q),
      .cmd      (bcmd_t'(snp_cmd)),
      .supplier (snp_supplier),
      .dec      (sd)
   );

   assign pr_ready  = !wait_q && !snp_valid;
   assign accept    = pr_valid && pr_ready;
   assign grant     = wait_q && bus_gnt;
   assign snp_take  = snp_valid && !grant;
   assign bus_req   = wait_q;
   assign bus_cmd   = cmd_q;
   assign coh_state = st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q           <= ST_I;
         line_q         <= '0;
         wait_q         <= 1'b0;
         pend_wr_q      <= 1'b0;
         pend_data_q    <= '0;
         cmd_q          <= CMD_RD;
         pr_done        <= 1'b0;
         pr_rdata       <= '0;
         snp_shared_out <= 1'b0;
         flush_valid    <= 1'b0;
         flush_data     <= '0;
         mem_wr         <= 1'b0;
      end else begin
         pr_done        <= 1'b0;
         snp_shared_out <= 1'b0;
         flush_valid    <= 1'b0;
         mem_wr         <= 1'b0;
         if (grant) begin
            wait_q  <= 1'b0;
            pr_done <= 1'b1;
            if (pend_wr_q) begin
               st_q     <= ST_M;
               line_q   <= pend_data_q;
               pr_rdata <= pend_data_q;
            end else begin
               st_q     <= bus_shared_in ? ST_S : ST_E;
               line_q   <= bus_fill_data;
               pr_rdata <= bus_fill_data;
            end
         end else if (snp_take) begin
            st_q           <= sd.nxt;
            flush_valid    <= sd.flush;
            flush_data     <= line_q;
            snp_shared_out <= sd.shared;
            mem_wr         <= sd.flush && sd.mem_upd;
         end else if (accept) begin
            if (pd.hit) begin
               st_q    <= pd.nxt;
               pr_done <= 1'b1;
               if (pr_write) begin
                  line_q   <= pr_wdata;
                  pr_rdata <= pr_wdata;
               end else begin
                  pr_rdata <= line_q;
               end
            end else begin
               wait_q      <= 1'b1;
               pend_wr_q   <= pr_write;
               pend_data_q <= pr_wdata;
               cmd_q       <= pd.cmd;
            end
         end
      end
   end
endmodule

// File: rtl/mesi_line_chk.sv
module mesi_line_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pr_valid,
   input logic       pr_write,
   input logic       pr_ready,
   input logic       pr_done,
   input logic       bus_req,
   input logic       bus_cmd,
   input logic       bus_gnt,
   input logic       bus_shared_in,
   input logic       snp_valid,
   input logic       snp_cmd,
   input logic       snp_shared_out,
   input logic       flush_valid,
   input logic       mem_wr,
   input logic [1:0] coh_state
);
   AST_RD_FILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && !bus_cmd && !bus_shared_in) |=> (coh_state == 2'd2 && pr_done)); // R1

   AST_SILENT_UPGRADE: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_valid && pr_ready && pr_write && coh_state == 2'd2) |=> (coh_state == 2'd3 && !bus_req && pr_done)); // R2

   AST_RDX_FILL_MOD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && bus_cmd) |=> (coh_state == 2'd3)); // R3

   AST_SNP_RDX_INV: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && !(bus_req && bus_gnt) && snp_cmd) |=> (coh_state == 2'd0 && !snp_shared_out)); // R6

   AST_SHARED_ON_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && !(bus_req && bus_gnt) && !snp_cmd && coh_state != 2'd0) |=> snp_shared_out); // R8

   AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && coh_state == 2'd0 && !(bus_req && bus_gnt)) |=> (!flush_valid && !snp_shared_out && !mem_wr)); // R9

   AST_MEMWR_WITH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (flush_valid && $past(coh_state) == 2'd3)); // R5

   AST_SNOOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !pr_ready); // R10
endmodule

bind mesi_line_ctrl mesi_line_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .pr_valid       (pr_valid),
   .pr_write       (pr_write),
   .pr_ready       (pr_ready),
   .pr_done        (pr_done),
   .bus_req        (bus_req),
   .bus_cmd        (bus_cmd),
   .bus_gnt        (bus_gnt),
   .bus_shared_in  (bus_shared_in),
   .snp_valid      (snp_valid),
   .snp_cmd        (snp_cmd),
   .snp_shared_out (snp_shared_out),
   .flush_valid    (flush_valid),
   .mem_wr         (mem_wr),
   .coh_state      (coh_state)
);

// File: tb/tb_mesi_line_ctrl.sv
module tb_mesi_line_ctrl;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pr_valid = 1'b0, pr_write = 1'b0;
   logic [DW-1:0] pr_wdata = '0;
   logic          pr_ready, pr_done;
   logic [DW-1:0] pr_rdata;
   logic          bus_req, bus_cmd;
   logic          bus_gnt = 1'b0, bus_shared_in = 1'b0;
   logic [DW-1:0] bus_fill_data = '0;
   logic          snp_valid = 1'b0, snp_cmd = 1'b0, snp_supplier = 1'b0;
   logic          snp_shared_out, flush_valid, mem_wr;
   logic [DW-1:0] flush_data;
   logic [1:0]    coh_state;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [1:0]    m_st;
   logic [DW-1:0] m_data;

   always #2 clk = ~clk;

   mesi_line_ctrl #(.DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .pr_valid(pr_valid), .pr_write(pr_write),
      .pr_wdata(pr_wdata), .pr_ready(pr_ready), .pr_done(pr_done),
      .pr_rdata(pr_rdata), .bus_req(bus_req), .bus_cmd(bus_cmd),
      .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
      .bus_fill_data(bus_fill_data), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
      .snp_supplier(snp_supplier), .snp_shared_out(snp_shared_out),
      .flush_valid(flush_valid), .flush_data(flush_data), .mem_wr(mem_wr),
      .coh_state(coh_state)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit exp_hit(input logic [1:0] st, input bit w);
      return w ? (st >= 2'd2) : (st != 2'd0);
   endfunction

   function automatic bit exp_flush(input logic [1:0] st, input bit sel);
      return (st >= 2'd2) || (st == 2'd1 && sel);
   endfunction

   function automatic logic [1:0] exp_snp_next(input logic [1:0] st, input bit cmd);
      if (st == 2'd0 || cmd) return 2'd0;
      return 2'd1;
   endfunction

   function automatic logic [1:0] exp_fill(input bit w, input bit sh);
      if (w) return 2'd3;
      return sh ? 2'd1 : 2'd2;
   endfunction

   task automatic do_snoop(input bit cmd, input bit sel);
      logic [1:0] pre;
      pre = m_st;
      snp_valid = 1'b1; snp_cmd = cmd; snp_supplier = sel;
      #1;
      chk(pr_ready == 1'b0, "R10 pr_ready low during snoop", pr_ready, 0);
      @(negedge clk);
      snp_valid = 1'b0;
      chk(flush_valid == exp_flush(pre, sel),
          pre == 2'd0 ? "R9 flush" : (cmd ? "R6 flush" : (pre == 2'd1 ? "R7 flush" : "R5 flush")),
          flush_valid, exp_flush(pre, sel));
      if (exp_flush(pre, sel))
         chk(flush_data == m_data, "R5 flush data", flush_data, m_data);
      chk(mem_wr == (pre == 2'd3), "R5 mem_wr", mem_wr, pre == 2'd3);
      chk(snp_shared_out == (!cmd && pre != 2'd0), "R8 shared out", snp_shared_out, !cmd && pre != 2'd0);
      m_st = exp_snp_next(pre, cmd);
      chk(coh_state == m_st, cmd ? "R6 state" : "R7 state", coh_state, m_st);
   endtask

   task automatic do_proc(input bit w, input logic [DW-1:0] d, input bit sh,
                          input int dly, input bit mid, input bit mcmd, input bit msel);
      bit hit;
      hit = exp_hit(m_st, w);
      pr_valid = 1'b1; pr_write = w; pr_wdata = d;
      #1;
      chk(pr_ready == 1'b1, "R10 pr_ready idle", pr_ready, 1);
      @(negedge clk);
      pr_valid = 1'b0;
      if (hit) begin
         if (w) begin
            m_data = d;
            if (m_st == 2'd2)
               chk(coh_state == 2'd3 && !bus_req, "R2 silent upgrade", coh_state, 3);
            m_st = 2'd3;
         end
         chk(pr_done == 1'b1 && bus_req == 1'b0, "R4 hit done no bus", {pr_done, bus_req}, 2'b10);
         chk(pr_rdata == m_data, "R4 hit data", pr_rdata, m_data);
         chk(coh_state == m_st, "R4 hit state", coh_state, m_st);
      end else begin
         chk(bus_req == 1'b1 && bus_cmd == w && !pr_done, w ? "R3 bus rdx" : "R1 bus rd",
             {bus_req, bus_cmd}, {1'b1, w});
         for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk(bus_req == 1'b1, "R1 request held", bus_req, 1);
         end
         if (mid) do_snoop(mcmd, msel);
         bus_gnt = 1'b1; bus_shared_in = sh; bus_fill_data = ~d;
         @(negedge clk);
         bus_gnt = 1'b0; bus_shared_in = 1'b0;
         m_st = exp_fill(w, sh);
         m_data = w ? d : ~d;
         chk(pr_done == 1'b1 && !bus_req, mid ? "R10 fill after snoop" : (w ? "R3 done" : "R1 done"),
             {pr_done, bus_req}, 2'b10);
         chk(coh_state == m_st, w ? "R3 fill state" : "R1 fill state", coh_state, m_st);
         chk(pr_rdata == m_data, w ? "R3 data" : "R1 data", pr_rdata, m_data);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      m_st = 2'd0; m_data = '0;
      repeat (3) @(negedge clk);
      chk(coh_state == 2'd0 && !pr_done && !bus_req && !flush_valid && !snp_shared_out && !mem_wr,
          "R11 reset", {coh_state, pr_done, bus_req, flush_valid, snp_shared_out, mem_wr}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corner cases
      do_snoop(1'b0, 1'b1);                        // R9 read snoop on I
      do_snoop(1'b1, 1'b1);                        // R9 rdx snoop on I
      do_proc(1'b0, 32'h1111_0000, 1'b0, 0, 0, 0, 0); // R1 fill E
      do_proc(1'b1, 32'hA5A5_0001, 1'b0, 0, 0, 0, 0); // R2 E->M silent
      do_proc(1'b1, 32'hA5A5_0002, 1'b0, 0, 0, 0, 0); // R4 write hit M
      do_snoop(1'b0, 1'b0);                        // R5 M flush, mem_wr, to S
      do_snoop(1'b0, 1'b0);                        // R7 S, not supplier
      do_snoop(1'b0, 1'b1);                        // R7 S, supplier
      do_proc(1'b0, 32'h0, 1'b0, 0, 0, 0, 0);      // R4 read hit S
      do_proc(1'b1, 32'h2222_3333, 1'b0, 2, 0, 0, 0); // R3 S->M via rdx
      do_snoop(1'b1, 1'b0);                        // R6 M rdx -> I
      do_proc(1'b0, 32'h4444_5555, 1'b1, 1, 0, 0, 0); // R1 fill S
      do_snoop(1'b1, 1'b1);                        // R6 S supplier rdx
      do_proc(1'b0, 32'h6666_7777, 1'b0, 0, 0, 0, 0); // R1 fill E
      do_snoop(1'b0, 1'b0);                        // R5 E flush no mem_wr
      do_proc(1'b1, 32'h8888_9999, 1'b0, 1, 1, 1, 0); // R10 snoop inside pending rdx
      // constrained random
      for (int n = 0; n < 400; n++) begin
         if ($urandom_range(0, 2) == 0)
            do_snoop($urandom_range(0, 1), $urandom_range(0, 1));
         else
            do_proc($urandom_range(0, 1), $urandom, $urandom_range(0, 1), $urandom_range(0, 3),
                    ($urandom_range(0, 3) == 0), $urandom_range(0, 1), $urandom_range(0, 1));
      end
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule